// File: doc/BRIEF.md
# Coincident-Current Core Memory Sequencer

This block runs the access cycles of a ferrite core array built from two bit-planes of 16 by 16 cores. That gives 256 addresses of 2 bits, one bit per plane. A host hands it one request at a time through a ready/request handshake. The block turns each request into two drive phases on the shared row and column lines. In the first phase, every plane's addressed core is driven toward zero. Each plane's sense flag is watched during a strobe window, and a flag seen there means that core held a one. In the second phase, the same lines are driven toward one. The per-plane inhibit line is raised on each plane whose new bit must stay zero.

The bit written in the second phase depends on the operation. A read puts back what it sensed, because reading erases the cores. A write stores host data. A read-modify-write stores the sensed word exclusive-ORed with host data, so a word can be changed with one clear/set pair. Every operation returns the sensed word when it completes. All phase timings are clock counts set by parameters. The sense flags, line enables, direction and inhibits are digital signals to and from analog drivers outside this block.

Top module: `coremem_seq`

## Requirements
- R1: Address bits [3:0] pick the column line and bits [7:4] pick the row line. While driving, `x_drv` has exactly bit addr[3:0] set and `y_drv` has exactly bit addr[7:4] set. Outside drive windows both are all zero, and only the addressed core in each plane may change.
- R2: `ready` is high only when the block is idle. A request is taken on a clock edge where `req` and `ready` are both high. `ready` then stays low until the access ends, so a request raised while busy waits and is taken only once `ready` returns.
- R3: Each access is a clear phase (`drv_dir`=0) followed by a set phase (`drv_dir`=1). Each phase lasts SETTLE_CYC + DRIVE_CYC + HOLD_CYC + RECOV_CYC clocks, with the lines driven only during its DRIVE_CYC part. `ack` appears exactly twice the phase length after the accepting edge, which is 28 clocks by default.
- R4: `drv_dir` and `inhibit` hold their values for at least one clock before the line enables rise and for at least one clock after they fall. `drv_dir` never changes while lines are driven.
- R5: `sense_strobe` is high only in the clear phase, on drive cycles STB_DLY through STB_DLY+STB_W-1 (3 and 4 by default, counting the first drive cycle as 0). A plane's sensed bit is 1 when its `sense_in` bit is high at any strobed clock edge.
- R6: `inhibit` is all zero when idle and during the clear phase. During the settle, drive and hold parts of the set phase, `inhibit[p]` is the inverse of the bit to be stored in plane p.
- R7: Operation code 01 (write) stores `wdata`.
- R8: Operation codes 00 and 11 (read) store the sensed word back, leaving the array unchanged.
- R9: Operation code 10 (read-modify-write) stores the sensed word XOR `wdata`.
- R10: `ack` is high for exactly one clock at the end of each access. While `ack` is high, `rd_data` holds the word sensed in that access's clear phase, whatever the operation.
- R11: While reset is held and right after it, `ready` is high and `ack`, `drv_dir`, `inhibit`, `sense_strobe`, `x_drv` and `y_drv` are all zero.
- R12: `sense_in` levels outside the strobe window are ignored. This covers the other clear-phase drive cycles, the set phase and the idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request |
| ready | output | 1 | Idle, request can be taken |
| op | input | 2 | Operation: 00/11 read, 01 write, 10 read-modify-write |
| addr | input | 8 | Word address: [3:0] column, [7:4] row |
| wdata | input | 2 | Host data, one bit per plane |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | 2 | Sensed word, valid with ack |
| x_drv | output | 16 | Column line half-current enables |
| y_drv | output | 16 | Row line half-current enables |
| drv_dir | output | 1 | Drive direction: 0 toward zero, 1 toward one |
| inhibit | output | 2 | Per-plane inhibit current enables |
| sense_strobe | output | 1 | Sense sampling window |
| sense_in | input | 2 | Per-plane sense detector flags |

## Verification
The bench models the cores. Its model raises a plane's sense flag only on strobe cycles where the driven core actually flips, and it injects spurious flags on every other cycle. A strobe window that is off by one cycle therefore loses ones, and a design that samples outside the window reads back ones that were never stored. Read, write and read-modify-write requests are applied back to back, with some raised while the block is busy. A read that restored the wrong word, an inhibit of the wrong polarity, or a request taken early would each show up as a wrong core value, a wrong returned word or a wrong completion latency. A final sweep of all 256 words catches a decoder that drives the wrong line and so changes a core other than the addressed one.

// File: rtl/coremem_pkg.sv
package coremem_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RMW   = 2'b10,
        OP_READ2 = 2'b11
    } cm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_DRIVE,
        ST_RELEASE,
        ST_RECOVER
    } cm_step_e;

    typedef enum logic {
        PH_CLEAR = 1'b0,
        PH_SET   = 1'b1
    } cm_phase_e;

    typedef struct packed {
        cm_op_e     op;
        logic [7:0] addr;
    } cm_cmd_t;

    function automatic int cm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Bit stored in the set phase for one plane
    function automatic logic cm_set_bit(input cm_op_e op, input logic sensed,
                                        input logic wbit);
        case (op)
            OP_WRITE: return wbit;
            OP_RMW:   return sensed ^ wbit;
            default:  return sensed;
        endcase
    endfunction

endpackage

// File: rtl/cm_line_decode.sv
module cm_line_decode #(
    parameter int SEL_W = 4,
    localparam int LINES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic [LINES-1:0] lines
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = en && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/cm_phase_seq.sv
module cm_phase_seq
    import coremem_pkg::*;
#(
    parameter int SETTLE_CYC = 1,
    parameter int DRIVE_CYC  = 8,
    parameter int HOLD_CYC   = 1,
    parameter int RECOV_CYC  = 4,
    parameter int STB_DLY    = 3,
    parameter int STB_W      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic idle,
    output logic drive_on,
    output logic dir_set,
    output logic inh_win,
    output logic strobe,
    output logic done
);
    localparam int MAXLEN = cm_max(cm_max(cm_max(SETTLE_CYC, DRIVE_CYC),
                                          cm_max(HOLD_CYC, RECOV_CYC)),
                                   STB_DLY + STB_W);
    localparam int CNT_W = $clog2(MAXLEN + 1);
    localparam logic [CNT_W-1:0] LAST_SETTLE = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_DRIVE  = CNT_W'(DRIVE_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_HOLD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_RECOV  = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] STB_LO      = CNT_W'(STB_DLY);
    localparam logic [CNT_W-1:0] STB_HI      = CNT_W'(STB_DLY + STB_W);

    cm_step_e         step;
    cm_phase_e        phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        case (step)
            ST_SETTLE:  last = LAST_SETTLE;
            ST_DRIVE:   last = LAST_DRIVE;
            ST_RELEASE: last = LAST_HOLD;
            default:    last = LAST_RECOV;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step  <= ST_IDLE;
            phase <= PH_CLEAR;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (step == ST_IDLE) begin
                cnt <= '0;
                if (start) begin
                    step  <= ST_SETTLE;
                    phase <= PH_CLEAR;
                end
            end else if (cnt == last) begin
                cnt <= '0;
                case (step)
                    ST_SETTLE:  step <= ST_DRIVE;
                    ST_DRIVE:   step <= ST_RELEASE;
                    ST_RELEASE: step <= ST_RECOVER;
                    default: begin
                        if (phase == PH_CLEAR) begin
                            phase <= PH_SET;
                            step  <= ST_SETTLE;
                        end else begin
                            phase <= PH_CLEAR;
                            step  <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign idle     = (step == ST_IDLE);
    assign drive_on = (step == ST_DRIVE);
    assign dir_set  = (phase == PH_SET) && (step != ST_IDLE);
    assign inh_win  = (phase == PH_SET) &&
                      (step == ST_SETTLE || step == ST_DRIVE || step == ST_RELEASE);
    assign strobe   = (step == ST_DRIVE) && (phase == PH_CLEAR) &&
                      (cnt >= STB_LO) && (cnt < STB_HI);
endmodule

// File: rtl/cm_plane_bit.sv
module cm_plane_bit
    import coremem_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear_cap,
    input  logic   strobe,
    input  logic   sense,
    input  cm_op_e op,
    input  logic   wbit,
    input  logic   inh_win,
    output logic   sensed,
    output logic   inhibit
);
    always_ff @(posedge clk) begin
        if (rst || clear_cap) begin
            sensed <= 1'b0;
        end else if (strobe && sense) begin
            sensed <= 1'b1;
        end
    end

    assign inhibit = inh_win && !cm_set_bit(op, sensed, wbit);
endmodule

// File: rtl/coremem_seq.sv
module coremem_seq
    import coremem_pkg::*;
#(
    parameter int X_SEL_W    = 4,
    parameter int Y_SEL_W    = 4,
    parameter int PLANES     = 2,
    parameter int SETTLE_CYC = 1,
    parameter int DRIVE_CYC  = 8,
    parameter int HOLD_CYC   = 1,
    parameter int RECOV_CYC  = 4,
    parameter int STB_DLY    = 3,
    parameter int STB_W      = 2,
    localparam int ADDR_W  = X_SEL_W + Y_SEL_W,
    localparam int X_LINES = 1 << X_SEL_W,
    localparam int Y_LINES = 1 << Y_SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    output logic               ready,
    input  logic [1:0]         op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [PLANES-1:0]  wdata,
    output logic               ack,
    output logic [PLANES-1:0]  rd_data,
    output logic [X_LINES-1:0] x_drv,
    output logic [Y_LINES-1:0] y_drv,
    output logic               drv_dir,
    output logic [PLANES-1:0]  inhibit,
    output logic               sense_strobe,
    input  logic [PLANES-1:0]  sense_in
);
    logic              accept;
    logic              idle, drive_on, dir_set, inh_win, strobe, done;
    cm_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PLANES-1:0] wdata_q;

    assign ready  = idle;
    assign accept = req && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_q    <= cm_op_e'(op);
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    cm_phase_seq #(
        .SETTLE_CYC(SETTLE_CYC), .DRIVE_CYC(DRIVE_CYC), .HOLD_CYC(HOLD_CYC),
        .RECOV_CYC(RECOV_CYC), .STB_DLY(STB_DLY), .STB_W(STB_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(accept), .idle(idle),
        .drive_on(drive_on), .dir_set(dir_set), .inh_win(inh_win),
        .strobe(strobe), .done(done)
    );

    cm_line_decode #(.SEL_W(X_SEL_W)) u_xdec (
        .sel(addr_q[X_SEL_W-1:0]), .en(drive_on), .lines(x_drv)
    );

    cm_line_decode #(.SEL_W(Y_SEL_W)) u_ydec (
        .sel(addr_q[ADDR_W-1:X_SEL_W]), .en(drive_on), .lines(y_drv)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        cm_plane_bit u_bit (
            .clk(clk), .rst(rst), .clear_cap(accept), .strobe(strobe),
            .sense(sense_in[p]), .op(op_q), .wbit(wdata_q[p]),
            .inh_win(inh_win), .sensed(rd_data[p]), .inhibit(inhibit[p])
        );
    end

    assign ack          = done;
    assign drv_dir      = dir_set;
    assign sense_strobe = strobe;
endmodule

// File: rtl/coremem_seq_chk.sv
module coremem_seq_chk #(
    parameter int X_LINES = 16,
    parameter int Y_LINES = 16,
    parameter int PLANES  = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               req,
    input logic               ready,
    input logic               ack,
    input logic [X_LINES-1:0] x_drv,
    input logic [Y_LINES-1:0] y_drv,
    input logic               drv_dir,
    input logic [PLANES-1:0]  inhibit,
    input logic               sense_strobe
);
    logic drv_on;
    assign drv_on = |x_drv;

    assert_one_line_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(x_drv) && $onehot0(y_drv) && ((|x_drv) == (|y_drv)));

    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !ready);

    assert_ends_in_set_R3: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(drv_dir));

    assert_settled_before_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_on) |-> ($stable(drv_dir) && $stable(inhibit)));

    assert_held_after_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_on) |-> ($stable(drv_dir) && $stable(inhibit)));

    assert_dir_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (drv_on && $past(drv_on)) |-> $stable(drv_dir));

    assert_strobe_in_clear_R5: assert property (@(posedge clk) disable iff (rst)
        sense_strobe |-> (drv_on && !drv_dir));

    assert_inhibit_in_set_R6: assert property (@(posedge clk) disable iff (rst)
        (|inhibit) |-> drv_dir);

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_reset_state_R11: assert property (@(posedge clk)
        $past(rst) |-> (ready && !ack && !drv_dir && inhibit == '0 && !drv_on));
endmodule

bind coremem_seq coremem_seq_chk #(
    .X_LINES(X_LINES), .Y_LINES(Y_LINES), .PLANES(PLANES)
) u_chk (
    .clk(clk), .rst(rst), .req(req), .ready(ready), .ack(ack),
    .x_drv(x_drv), .y_drv(y_drv), .drv_dir(drv_dir), .inhibit(inhibit),
    .sense_strobe(sense_strobe)
);

// File: tb/coremem_seq_test.sv
module coremem_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        ready;
    logic [1:0]  op = 2'b00;
    logic [7:0]  addr = 8'h00;
    logic [1:0]  wdata = 2'b00;
    logic        ack;
    logic [1:0]  rd_data;
    logic [15:0] x_drv, y_drv;
    logic        drv_dir;
    logic [1:0]  inhibit;
    logic        sense_strobe;
    logic [1:0]  sense_in = 2'b00;

    always #2 clk = ~clk;

    coremem_seq uut (
        .clk(clk), .rst(rst), .req(req), .ready(ready), .op(op), .addr(addr),
        .wdata(wdata), .ack(ack), .rd_data(rd_data), .x_drv(x_drv),
        .y_drv(y_drv), .drv_dir(drv_dir), .inhibit(inhibit),
        .sense_strobe(sense_strobe), .sense_in(sense_in)
    );

    typedef struct {
        logic [7:0] a;
        logic [1:0] rd;
        logic [1:0] nw;
        logic [1:0] o;
        int         acc;
        bit         noisy;
    } item_t;

    item_t      sb[$];
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;
    bit         ended = 0;
    logic [1:0] exp_m [256];
    logic [1:0] core_m [256];
    logic       noise_en = 1'b0;

    always @(posedge clk) cyc++;

    // Core array model: flips only the addressed core, pulses sense on the
    // strobe cycles of a flipping clear drive, noise elsewhere when enabled.
    logic        was_on = 1'b0;
    int          drv_idx = 0;
    logic [1:0]  flip = 2'b00;
    logic [15:0] seen_x = '0, seen_y = '0;
    always @(negedge clk) begin
        logic       on;
        int         ax, ay;
        logic [7:0] a;
        if (rst) begin
            for (int i = 0; i < 256; i++) core_m[i] = 2'(i ^ (i >> 4));
        end
        on = (|x_drv) && (|y_drv);
        if (on) begin
            ax = 0; ay = 0;
            for (int i = 0; i < 16; i++) begin
                if (x_drv[i]) ax = i;
                if (y_drv[i]) ay = i;
            end
            a = 8'(ay * 16 + ax);
            if (!was_on) begin
                drv_idx = 0; seen_x = x_drv; seen_y = y_drv;
            end else begin
                drv_idx++;
            end
            if (!drv_dir) begin
                if (!was_on) flip = core_m[a];
                core_m[a] = 2'b00;
            end else begin
                for (int p = 0; p < 2; p++) if (!inhibit[p]) core_m[a][p] = 1'b1;
            end
        end
        if (on && !drv_dir)
            sense_in = (drv_idx >= 3 && drv_idx < 5) ? flip : (noise_en ? 2'b11 : 2'b00);
        else
            sense_in = noise_en ? 2'b11 : 2'b00;
        was_on = on;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    function automatic string op_tag(input logic [1:0] o, input bit noisy);
        if (noisy) return "R12";
        case (o)
            2'b01:   return "R7";
            2'b10:   return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic do_op(input logic [1:0] o, input logic [7:0] ad, input logic [1:0] wd);
        item_t it;
        it.a = ad; it.o = o; it.noisy = noise_en;
        it.rd = exp_m[ad];
        it.nw = (o == 2'b01) ? wd : (o == 2'b10) ? (exp_m[ad] ^ wd) : exp_m[ad];
        exp_m[ad] = it.nw;
        @(negedge clk);
        req = 1'b1; op = o; addr = ad; wdata = wd;
        while (!ready) @(negedge clk);   // held off while busy (R2)
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        it.acc = cyc;
        sb.push_back(it);
        chk(ready == 1'b0, "R2", "ready after accept", 32'(ready), 0);
    endtask

    task automatic monitor();
        forever begin
            @(negedge clk);
            if (ack) begin
                item_t it;
                if (sb.size() == 0) begin
                    chk(0, "R10", "ack with nothing pending", 1, 0);
                end else begin
                    it = sb.pop_front();
                    chk(rd_data == it.rd, "R10", "returned word", 32'(rd_data), 32'(it.rd));
                    chk(core_m[it.a] == it.nw, op_tag(it.o, it.noisy), "stored word",
                        32'(core_m[it.a]), 32'(it.nw));
                    chk(cyc - it.acc == 28, "R3", "accept to ack clocks",
                        32'(cyc - it.acc), 28);
                    chk(seen_x == (16'h1 << it.a[3:0]) && seen_y == (16'h1 << it.a[7:4]),
                        "R1", "line select", {seen_y, seen_x},
                        {16'h1 << it.a[7:4], 16'h1 << it.a[3:0]});
                end
            end
        end
    endtask

    task automatic watchdog();
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            chk(0, "WATCHDOG", "run did not finish", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        logic [15:0] lf;
        int          bad;
        for (int i = 0; i < 256; i++) exp_m[i] = 2'(i ^ (i >> 4));
        fork
            monitor();
            watchdog();
        join_none
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: state while reset is held
        chk(ready && !ack && !drv_dir && inhibit == 0 && !sense_strobe &&
            x_drv == 0 && y_drv == 0, "R11", "reset outputs", 32'(ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(ready && !ack && x_drv == 0 && inhibit == 0, "R11", "after reset",
            32'(ready), 1);

        // Directed: write, read, modify, read at the lowest address
        do_op(2'b01, 8'h00, 2'b10);
        do_op(2'b00, 8'h00, 2'b00);
        do_op(2'b10, 8'h00, 2'b11);
        do_op(2'b11, 8'h00, 2'b00);
        // Highest address, repeated reads must restore
        do_op(2'b01, 8'hFF, 2'b11);
        do_op(2'b00, 8'hFF, 2'b00);
        do_op(2'b00, 8'hFF, 2'b00);
        // All-zero word read, and clear via modify
        do_op(2'b01, 8'h5A, 2'b00);
        do_op(2'b00, 8'h5A, 2'b00);
        do_op(2'b10, 8'hA5, exp_m[8'hA5]);
        do_op(2'b00, 8'hA5, 2'b00);

        // Pseudo-random mix of all op codes
        lf = 16'hACE1;
        for (int k = 0; k < 60; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_op(lf[1:0], lf[15:8], lf[3:2]);
        end

        // R12: spurious sense flags outside the strobe window
        @(negedge clk);
        wait (sb.size() == 0);
        noise_en = 1'b1;
        do_op(2'b01, 8'h33, 2'b00);
        do_op(2'b00, 8'h33, 2'b00);
        do_op(2'b10, 8'h33, 2'b01);
        do_op(2'b00, 8'h33, 2'b00);
        do_op(2'b00, 8'hC4, 2'b00);
        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
        chk(rd_data == 2'b00 || rd_data == exp_m[8'hC4], "R12", "idle noise ignored",
            32'(rd_data), 32'(exp_m[8'hC4]));
        noise_en = 1'b0;

        repeat (5) @(negedge clk);
        // R1: no core other than addressed ones disturbed
        bad = 0;
        for (int i = 0; i < 256; i++) if (core_m[i] != exp_m[i]) bad++;
        chk(bad == 0, "R1", "array words differing", 32'(bad), 0);
        chk(ready && !ack && x_drv == 0 && inhibit == 0, "R6", "idle outputs",
            32'(inhibit), 0);

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule